// File: doc/BRIEF.md
# Time-of-Day Counter with Synchronous Digit Cascade

This block keeps hours, minutes and seconds as three separate binary fields. Each field comes from one modulo-N digit counter: seconds wrap at 60, minutes wrap at 60 and hours wrap at 24. A one-cycle `tick` input advances the seconds digit by one. Each digit raises a combinational carry flag in the cycle where it is about to wrap. That flag is the advance input of the next digit, so a carry through all three digits settles on one clock edge.

All digit registers share the same clock. A carry never drives a clock input; it only acts as an enable. A synchronous clear returns all three digits to zero on the next rising edge. The hours digit's carry comes out as `day_o`, which marks the tick that closes a full day.

Top module: `tod_counter`

## Requirements
- R1: When `clr` is high at a rising edge, `sec_o`, `min_o` and `hr_o` are all 0 after that edge, whatever the value of `tick`.
- R2: When `clr` and `tick` are both low at a rising edge, all three count outputs keep their values across that edge.
- R3: When `clr` is low, `tick` is high and `sec_o` is below 59, `sec_o` rises by exactly one at the edge.
- R4: When `clr` is low, `tick` is high and `sec_o` is 59, `sec_o` becomes 0 and the minutes digit advances by one at the same edge, wrapping from 59 to 0.
- R5: A digit's carry flag (and `day_o` for the hours digit) is high exactly when `clr` is low, the digit's advance input is high and the digit holds its top value (59, 59 or 23). Otherwise it is low, including while `clr` is high.
- R6: `min_o` changes only on an edge where the seconds carry is high. `hr_o` changes only on an edge where the minutes carry is high.
- R7: In state 23:59:59 with `tick` high and `clr` low, `day_o` is high in that cycle, and the next edge produces 00:00:00 with `day_o` low again.
- R8: `sec_o` stays below 60, `min_o` below 60 and `hr_o` below 24 at every edge after the first clear.
- R9: Starting from clear, after k ticks the outputs equal hours = k div 3600, minutes = (k div 60) mod 60 and seconds = k mod 60, where k counts modulo 86400. Exactly one `day_o` pulse occurs per 86400 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for every digit register |
| clr | input | 1 | Synchronous clear of all digits; takes priority over tick |
| tick | input | 1 | Advance request for the seconds digit |
| sec_o | output | 6 | Seconds count, 0 to 59 |
| min_o | output | 6 | Minutes count, 0 to 59 |
| hr_o | output | 5 | Hours count, 0 to 23 |
| day_o | output | 1 | Hours carry; high in the cycle whose tick wraps 23:59:59 |

## Verification
The counter runs through an unbroken stream of 86400 ticks from clear. This stream tells apart a plain seconds step, a seconds-only wrap, a wrap that carries into the hours digit, and the full three-digit wrap at the end of the day. Idle stretches with `tick` low come before and inside the run, and they separate holding from advancing. A clear is issued mid-count, once with `tick` low and once with `tick` high. These two cases show that clear overrides the advance and that the carry flag stays quiet during clear. A reference model that counts seconds of the day predicts every digit after each edge, and the `day_o` level in each cycle.

// File: rtl/tod_pkg.sv
package tod_pkg;

  localparam int unsigned SECS_PER_MIN = 60;
  localparam int unsigned MINS_PER_HR  = 60;
  localparam int unsigned HRS_PER_DAY  = 24;

  // Value a modulo-m digit takes after one advance.
  function automatic logic [31:0] digit_advance(input logic [31:0] cur,
                                                input int unsigned m);
    logic [31:0] nxt;
    if (cur >= 32'(m - 1)) nxt = '0;
    else                   nxt = cur + 32'd1;
    return nxt;
  endfunction

  // True when a modulo-m digit holds its top value.
  function automatic logic digit_at_top(input logic [31:0] cur,
                                        input int unsigned m);
    return cur == 32'(m - 1);
  endfunction

endpackage

// File: rtl/tod_carry_flag.sv
module tod_carry_flag #(
  parameter int unsigned MOD = 60,
  localparam int unsigned W  = $clog2(MOD)
) (
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] value,
  output logic         carry
);
  logic top_hit;

  always_comb begin
    top_hit = tod_pkg::digit_at_top(32'(value), MOD);
    carry   = !clr && adv && top_hit;
  end

endmodule

// File: rtl/tod_digit.sv
module tod_digit #(
  parameter int unsigned MOD = 60,
  localparam int unsigned W  = $clog2(MOD)
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         adv,
  output logic [W-1:0] value_o,
  output logic         carry_o
);
  logic [W-1:0] value_q;
  logic [W-1:0] value_d;

  always_comb begin
    if (clr)      value_d = '0;
    else if (adv) value_d = W'(tod_pkg::digit_advance(32'(value_q), MOD));
    else          value_d = value_q;
  end

  always_ff @(posedge clk) begin
    value_q <= value_d;
  end

  tod_carry_flag #(.MOD(MOD)) u_carry (
    .clr   (clr),
    .adv   (adv),
    .value (value_q),
    .carry (carry_o)
  );

  assign value_o = value_q;

endmodule

// File: rtl/tod_counter.sv
module tod_counter #(
  parameter int unsigned SEC_MOD = tod_pkg::SECS_PER_MIN,
  parameter int unsigned MIN_MOD = tod_pkg::MINS_PER_HR,
  parameter int unsigned HR_MOD  = tod_pkg::HRS_PER_DAY,
  localparam int unsigned SW = $clog2(SEC_MOD),
  localparam int unsigned MW = $clog2(MIN_MOD),
  localparam int unsigned HW = $clog2(HR_MOD)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          tick,
  output logic [SW-1:0] sec_o,
  output logic [MW-1:0] min_o,
  output logic [HW-1:0] hr_o,
  output logic          day_o
);
  // Carry events between digits, named for the checker.
  logic sec_roll;
  logic min_roll;
  logic hr_roll;

  tod_digit #(.MOD(SEC_MOD)) u_sec (
    .clk     (clk),
    .clr     (clr),
    .adv     (tick),
    .value_o (sec_o),
    .carry_o (sec_roll)
  );

  tod_digit #(.MOD(MIN_MOD)) u_min (
    .clk     (clk),
    .clr     (clr),
    .adv     (sec_roll),
    .value_o (min_o),
    .carry_o (min_roll)
  );

  tod_digit #(.MOD(HR_MOD)) u_hr (
    .clk     (clk),
    .clr     (clr),
    .adv     (min_roll),
    .value_o (hr_o),
    .carry_o (hr_roll)
  );

  assign day_o = hr_roll;

endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
  parameter int unsigned SEC_MOD = 60,
  parameter int unsigned MIN_MOD = 60,
  parameter int unsigned HR_MOD  = 24,
  localparam int unsigned SW = $clog2(SEC_MOD),
  localparam int unsigned MW = $clog2(MIN_MOD),
  localparam int unsigned HW = $clog2(HR_MOD)
) (
  input logic          clk,
  input logic          clr,
  input logic          tick,
  input logic [SW-1:0] sec_o,
  input logic [MW-1:0] min_o,
  input logic [HW-1:0] hr_o,
  input logic          day_o,
  input logic          sec_roll,
  input logic          min_roll
);
  localparam logic [SW-1:0] SEC_TOP = SW'(SEC_MOD - 1);
  localparam logic [MW-1:0] MIN_TOP = MW'(MIN_MOD - 1);
  localparam logic [HW-1:0] HR_TOP  = HW'(HR_MOD - 1);

  logic clr_seen = 1'b0;
  logic clr_q    = 1'b0;

  always @(posedge clk) begin
    // R1
    if (clr_q) begin
      clear_zero_chk: assert (sec_o == '0 && min_o == '0 && hr_o == '0);
    end
    // R8
    if (clr_seen && !clr) begin
      digit_range_chk: assert (sec_o < SW'(SEC_MOD) && min_o < MW'(MIN_MOD) && hr_o < HW'(HR_MOD));
    end
    clr_q <= clr;
    if (clr) clr_seen <= 1'b1;
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (clr)
    !tick |=> ($stable(sec_o) && $stable(min_o) && $stable(hr_o)));

  // R3
  sec_step_chk: assert property (@(posedge clk) disable iff (clr)
    (tick && sec_o != SEC_TOP) |=> (sec_o == $past(sec_o) + 1'b1));

  // R4
  sec_wrap_chk: assert property (@(posedge clk) disable iff (clr)
    sec_roll |=> (sec_o == '0 && min_o != $past(min_o)));

  // R5
  sec_roll_cause_chk: assert property (@(posedge clk) disable iff (clr)
    sec_roll |-> (tick && sec_o == SEC_TOP));

  // R5
  sec_roll_when_chk: assert property (@(posedge clk) disable iff (clr)
    (tick && sec_o == SEC_TOP) |-> sec_roll);

  // R5
  min_roll_cause_chk: assert property (@(posedge clk) disable iff (clr)
    min_roll |-> (sec_roll && min_o == MIN_TOP));

  // R6
  min_quiet_chk: assert property (@(posedge clk) disable iff (clr)
    !sec_roll |=> $stable(min_o));

  // R6
  hr_quiet_chk: assert property (@(posedge clk) disable iff (clr)
    !min_roll |=> $stable(hr_o));

  // R7
  day_state_chk: assert property (@(posedge clk) disable iff (clr)
    day_o |-> (hr_o == HR_TOP && min_o == MIN_TOP && sec_o == SEC_TOP && tick));

  // R7
  day_wrap_chk: assert property (@(posedge clk) disable iff (clr)
    day_o |=> (hr_o == '0 && min_o == '0 && sec_o == '0 && !day_o));

  // R5
  clr_quiet_chk: assert property (@(posedge clk)
    clr |-> (!sec_roll && !min_roll && !day_o));

endmodule

bind tod_counter tod_counter_chk #(
  .SEC_MOD (SEC_MOD),
  .MIN_MOD (MIN_MOD),
  .HR_MOD  (HR_MOD)
) u_chk (
  .clk      (clk),
  .clr      (clr),
  .tick     (tick),
  .sec_o    (sec_o),
  .min_o    (min_o),
  .hr_o     (hr_o),
  .day_o    (day_o),
  .sec_roll (sec_roll),
  .min_roll (min_roll)
);

// File: tb/tod_counter_test.sv
module tod_counter_test;
  localparam int DAY_SECS = 86400;

  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic       tick = 1'b0;
  logic [5:0] sec_o;
  logic [5:0] min_o;
  logic [4:0] hr_o;
  logic       day_o;

  int checks = 0;
  int fails  = 0;
  int tod    = 0;
  int day_pulses = 0;
  int ticks_since_clr = 0;

  int    q_hr[$];
  int    q_min[$];
  int    q_sec[$];
  string q_tag[$];

  always #2 clk = ~clk;

  tod_counter uut (
    .clk   (clk),
    .clr   (clr),
    .tick  (tick),
    .sec_o (sec_o),
    .min_o (min_o),
    .hr_o  (hr_o),
    .day_o (day_o)
  );

  task automatic check_int(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, a day-flag check, and one expected item.
  task automatic drive(input logic t, input logic c);
    int    nxt;
    string tag;
    @(negedge clk);
    tick = t;
    clr  = c;
    #1;
    // R5 R7: day flag level in this cycle
    check_int("R5", "day_o", int'(day_o), (!c && t && tod == DAY_SECS - 1) ? 1 : 0);
    if (!c && t && tod == DAY_SECS - 1) day_pulses++;
    if (c)                          tag = "R1";
    else if (!t)                    tag = "R2";
    else if (tod == DAY_SECS - 1)   tag = "R7";
    else if (tod % 3600 == 3599)    tag = "R6";
    else if (tod % 60 == 59)        tag = "R4";
    else                            tag = "R3";
    if (c)      nxt = 0;
    else if (t) nxt = (tod + 1 == DAY_SECS) ? 0 : tod + 1;
    else        nxt = tod;
    if (c)      ticks_since_clr = 0;
    else if (t) ticks_since_clr++;
    tod = nxt;
    q_hr.push_back(nxt / 3600);
    q_min.push_back((nxt % 3600) / 60);
    q_sec.push_back(nxt - (nxt / 60) * 60);
    q_tag.push_back(tag);
  endtask

  // Monitor: compare the outputs just after each edge with the queued item.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_tag.size() > 0) begin
        string tag;
        tag = q_tag.pop_front();
        check_int(tag, "hr_o",  int'(hr_o),  q_hr.pop_front());
        check_int(tag, "min_o", int'(min_o), q_min.pop_front());
        check_int(tag, "sec_o", int'(sec_o), q_sec.pop_front());
        // R8
        check_int("R8", "digits in range",
                  int'(sec_o < 60 && min_o < 60 && hr_o < 24), 1);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R9 watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    drive(1'b0, 1'b1);
    drive(1'b1, 1'b1);
    // R2: idle cycles hold zero
    repeat (4) drive(1'b0, 1'b0);
    // R3 R4: a few ticks, then idle in the middle of a count
    repeat (75) drive(1'b1, 1'b0);
    repeat (3) drive(1'b0, 1'b0);
    // R1: clear mid-count with tick low, then with tick high
    drive(1'b0, 1'b1);
    repeat (130) drive(1'b1, 1'b0);
    drive(1'b1, 1'b1);
    // R9: full day from clear, idle gaps included
    day_pulses = 0;
    for (int i = 0; i < DAY_SECS; i++) begin
      drive(1'b1, 1'b0);
      if (i == 40000) repeat (2) drive(1'b0, 1'b0);
    end
    // R7: after wrap, idle and a final step
    repeat (2) drive(1'b0, 1'b0);
    drive(1'b1, 1'b0);
    @(negedge clk);
    tick = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    // R9: one day pulse per full day of ticks
    check_int("R9", "day pulses", day_pulses, 1);
    check_int("R9", "ticks since clear", ticks_since_clr, DAY_SECS + 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule